// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits beside a 32-bit memory data path and protects it with one parity bit per byte lane. During a write data cycle it computes the four lane parity bits from the outgoing data and drives them onto the parity lines, raising an output enable for that cycle only. During a read data cycle it computes parity from the incoming data and compares the result with the parity bits that arrive with it. Any lane that mismatches is reported through a one-cycle error pulse in the following clock.

Only lanes with their byte enable asserted take part. A lane that is not enabled drives a zero parity bit and can never flag an error. Two configuration inputs set the parity sense (even or odd) and turn read checking on or off. A sticky lane mask collects every failing lane until a write-one-to-clear input removes its bits.

Top module: `lane_parity_unit`

## Requirements
- R1: Parity bit i covers data bits 8*i+7 down to 8*i, for i = 0..3.
- R2: With `cfg_odd`=0, each generated parity bit makes the count of ones in its byte plus that bit even. With `cfg_odd`=1, the count is odd.
- R3: `par_oe` is 1 exactly in cycles where `dcyc_i`=1 and `wr_i`=1. `par_o` is all zero whenever `par_oe` is 0, and a lane whose `be_i` bit is 0 drives a 0 parity bit.
- R4: A read data cycle (`dcyc_i`=1, `wr_i`=0) with checking on and a mismatch in an enabled lane gives `err_pulse`=1 in the next cycle only. If the following cycle is clean, the pulse is gone one cycle later.
- R5: A lane whose `be_i` bit is 0 never raises an error and never sets its bit in `err_mask`.
- R6: `err_mask` bit i is set in the cycle after a read mismatch on lane i. It stays set until it is cleared.
- R7: Writing 1 to bit i of `clr_mask` clears `err_mask` bit i at the next edge. A new error on the same lane in the same cycle wins over the clear.
- R8: With `cfg_chk_en`=0, reads produce no pulse and leave `err_mask` unchanged. Write parity is still generated.
- R9: After synchronous reset, `err_pulse` is 0 and `err_mask` is 0.
- R10: Write data cycles never produce an error, whatever value is on `par_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chk_en | input | 1 | Read parity checking enable |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| clr_mask | input | 4 | Write-one-to-clear for the sticky lane mask |
| dcyc_i | input | 1 | Data cycle strobe |
| wr_i | input | 1 | 1 = write data cycle, 0 = read data cycle |
| be_i | input | 4 | Active-high byte enables, bit i for lane i |
| dat_i | input | 32 | Data bus |
| par_i | input | 4 | Received parity bits on reads |
| par_o | output | 4 | Generated parity bits on writes |
| par_oe | output | 1 | Parity line output enable |
| err_pulse | output | 1 | One-cycle read parity error pulse |
| err_mask | output | 4 | Sticky failing-lane mask |

## Verification
The hardest case to reach from the ports is an error and a clear landing on the same lane in the same cycle, because the clear must be applied in the very cycle that the bad read data is presented. The bench first plants a bit in the mask. It then drives a failing read on that lane together with the matching `clr_mask` bit, and expects the bit to survive. A second, near-exhaustive sweep runs every byte-enable pattern against every injected lane-error pattern, so that masked and unmasked lanes meet in all combinations.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/lpar_lane_gen.sv
module lpar_lane_gen #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] byte_i,
  input  logic              odd_i,
  output logic              par_o
);
  // even sense: reduction XOR already makes total ones even
  always_comb par_o = (^byte_i) ^ odd_i;
endmodule

// File: rtl/lpar_err_track.sv
module lpar_err_track #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_stb,
  input  logic [LANES-1:0] bad_lanes,
  input  logic [LANES-1:0] clr_mask,
  output logic             err_pulse,
  output logic [LANES-1:0] err_mask
);
  logic [LANES-1:0] hit;
  always_comb hit = chk_stb ? bad_lanes : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_mask  <= '0;
    end else begin
      err_pulse <= |hit;
      err_mask  <= (err_mask & ~clr_mask) | hit;
    end
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int unsigned LANES  = lpar_pkg::LANES,
  parameter int unsigned LANE_W = lpar_pkg::LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_chk_en,
  input  logic                    cfg_odd,
  input  logic [LANES-1:0]        clr_mask,
  input  logic                    dcyc_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] dat_i,
  input  logic [LANES-1:0]        par_i,
  output logic [LANES-1:0]        par_o,
  output logic                    par_oe,
  output logic                    err_pulse,
  output logic [LANES-1:0]        err_mask
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [LANES-1:0] calc_par;
  logic [LANES-1:0] bad_lanes;
  logic             wr_cyc;
  logic             rd_chk;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      lpar_lane_gen #(.LANE_W(LANE_W)) gen_i (
        .byte_i (dat_i[g*LANE_W +: LANE_W]),
        .odd_i  (cfg_odd),
        .par_o  (calc_par[g])
      );
    end
  endgenerate

  always_comb begin
    wr_cyc    = dcyc_i & wr_i;
    rd_chk    = dcyc_i & ~wr_i & cfg_chk_en;
    par_oe    = wr_cyc;
    par_o     = wr_cyc ? (calc_par & be_i) : '0;
    bad_lanes = (calc_par ^ par_i) & be_i;
  end

  lpar_err_track #(.LANES(LANES)) trk_i (
    .clk       (clk),
    .rst       (rst),
    .chk_stb   (rd_chk),
    .bad_lanes (bad_lanes),
    .clr_mask  (clr_mask),
    .err_pulse (err_pulse),
    .err_mask  (err_mask)
  );

  initial begin
    if (DATA_W != LANES * LANE_W) $error("width mismatch");
  end
endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_chk_en,
  input logic             dcyc_i,
  input logic             wr_i,
  input logic [LANES-1:0] be_i,
  input logic [LANES-1:0] clr_mask,
  input logic [LANES-1:0] par_o,
  input logic             par_oe,
  input logic             err_pulse,
  input logic [LANES-1:0] err_mask
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !par_oe |-> (par_o == '0));

  p_masked_lane_zero_r3: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> ((par_o & ~be_i) == '0));

  p_pulse_from_read_r4: assert property (@(posedge clk) disable iff (rst)
    (dcyc_i && wr_i) |=> !err_pulse);

  p_no_check_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_chk_en |=> !err_pulse);

  p_no_check_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_chk_en && clr_mask == '0) |=> $stable(err_mask));

  p_mask_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_mask == '0) |=> ((err_mask & $past(err_mask)) == $past(err_mask)));

  p_disabled_lane_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_mask & ~$past(err_mask) & ~$past(be_i)) == '0));
endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .cfg_chk_en(cfg_chk_en), .dcyc_i(dcyc_i), .wr_i(wr_i),
  .be_i(be_i), .clr_mask(clr_mask), .par_o(par_o), .par_oe(par_oe),
  .err_pulse(err_pulse), .err_mask(err_mask)
);

// File: tb/lane_parity_unit_tb_top.sv
`timescale 1ns/1ps
module lane_parity_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_chk_en = 1'b1, cfg_odd = 1'b0;
  logic [3:0]  clr_mask = '0;
  logic        dcyc_i = 1'b0, wr_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic [31:0] dat_i = '0;
  logic [3:0]  par_i = '0;
  logic [3:0]  par_o;
  logic        par_oe, err_pulse;
  logic [3:0]  err_mask;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_parity_unit dut_i (
    .clk(clk), .rst(rst), .cfg_chk_en(cfg_chk_en), .cfg_odd(cfg_odd),
    .clr_mask(clr_mask), .dcyc_i(dcyc_i), .wr_i(wr_i), .be_i(be_i),
    .dat_i(dat_i), .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
    .err_pulse(err_pulse), .err_mask(err_mask)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_par(logic [31:0] d, logic odd);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += d[8*l+b];
      p[l] = ((ones % 2) != 0) ^ odd;
    end
    return p;
  endfunction

  // read cycle: drive at negedge, registered outputs checked one edge later
  task automatic do_read(logic [31:0] d, logic [3:0] be, logic [3:0] inj,
                         logic [3:0] clr, logic [3:0] mask_before, string req);
    logic [3:0] hit;
    @(negedge clk);
    dcyc_i = 1; wr_i = 0; be_i = be; dat_i = d; clr_mask = clr;
    par_i = ref_par(d, cfg_odd) ^ inj;
    #1 chk("R3 oe low on read", {31'd0, par_oe}, 32'd0);
    hit = cfg_chk_en ? (inj & be) : 4'b0;
    @(negedge clk);
    dcyc_i = 0; clr_mask = '0;
    chk({req, " pulse"}, {31'd0, err_pulse}, {31'd0, |hit});
    chk({req, " mask"}, {28'd0, err_mask}, {28'd0, (mask_before & ~clr) | hit});
  endtask

  task automatic clear_all();
    @(negedge clk); clr_mask = 4'hF;
    @(negedge clk); clr_mask = 4'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 pulse after reset", {31'd0, err_pulse}, 32'd0);
    chk("R9 mask after reset", {28'd0, err_mask}, 32'd0);
    rst = 0;

    // R1 R2: exhaustive byte values, both senses, all lanes distinct
    for (int pol = 0; pol < 2; pol++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] d;
        d = {8'(v), 8'(v ^ 8'h5a), 8'(~v), 8'(v + 1)};
        @(negedge clk);
        cfg_odd = pol[0]; dcyc_i = 1; wr_i = 1; be_i = 4'hF; dat_i = d;
        par_i = ~ref_par(d, pol[0]);
        #1;
        chk("R1 R2 write parity", {28'd0, par_o}, {28'd0, ref_par(d, pol[0])});
        chk("R3 oe on write", {31'd0, par_oe}, 32'd1);
        @(negedge clk);
        dcyc_i = 0;
        chk("R10 no error on write", {31'd0, err_pulse}, 32'd0);
        #1 chk("R3 idle parity zero", {27'd0, par_oe, par_o}, 32'd0);
      end
    end
    cfg_odd = 0;

    // R3: byte enables mask generated parity
    for (int be = 0; be < 16; be++) begin
      @(negedge clk);
      dcyc_i = 1; wr_i = 1; be_i = 4'(be); dat_i = 32'h01030107;
      #1 chk("R3 masked write lanes", {28'd0, par_o}, {28'd0, ref_par(32'h01030107, 0) & 4'(be)});
    end
    @(negedge clk); dcyc_i = 0;
    chk("R10 mask after writes", {28'd0, err_mask}, 32'd0);

    // R4 R5 R6: every enable pattern against every injected error pattern
    for (int be = 0; be < 16; be++) begin
      for (int inj = 0; inj < 16; inj++) begin
        cfg_odd = inj[0] ^ be[1];
        do_read(32'h9e3779b9 ^ (be * 32'h01010101) ^ inj, 4'(be), 4'(inj), 4'h0, 4'h0,
                "R4 R5 R6 read");
        @(negedge clk);
        chk("R4 pulse one cycle", {31'd0, err_pulse}, 32'd0);
        chk("R6 mask held", {28'd0, err_mask}, {28'd0, 4'(inj) & 4'(be)});
        clear_all();
      end
    end
    cfg_odd = 0;

    // R6 accumulation
    do_read(32'h12345678, 4'hF, 4'b0001, 4'h0, 4'h0, "R6 acc a");
    do_read(32'h87654321, 4'hF, 4'b0100, 4'h0, 4'b0001, "R6 acc b");
    // R7: clear of one bit, then error and clear on the same lane together
    do_read(32'hcafef00d, 4'hF, 4'b0000, 4'b0001, 4'b0101, "R7 partial clear");
    do_read(32'hcafef00d, 4'hF, 4'b0100, 4'b0100, 4'b0100, "R7 set wins");
    chk("R7 set wins bit", {28'd0, err_mask}, 32'h4);
    clear_all();

    // R8: checking off
    cfg_chk_en = 0;
    do_read(32'hdeadbeef, 4'hF, 4'hF, 4'h0, 4'h0, "R8 check off");
    @(negedge clk);
    dcyc_i = 1; wr_i = 1; be_i = 4'hF; dat_i = 32'h00ff0103;
    #1 chk("R8 write parity still generated", {28'd0, par_o}, {28'd0, ref_par(32'h00ff0103, 0)});
    @(negedge clk); dcyc_i = 0;
    cfg_chk_en = 1;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule